// File: doc/BRIEF.md
# Tree-PLRU TLB Victim Selector

This block chooses which entry of a fully associative translation buffer is replaced next, and it keeps the recency history that this choice depends on. The history is a binary tree of most-recently-used bits, one bit for each internal node over the entries. Each bit records which half of its subtree was touched more recently. Hits and allocations move the bits along the path to the touched entry. When a victim is needed, the tree is walked toward the less recently used side at every node.

The choice follows a fixed order. A software-forced index overrides everything else. Next comes the lowest-numbered entry that is both empty and unlocked. Next comes the tree leaf, as long as that leaf is not locked. The last fallback is the lowest-numbered unlocked entry. If every entry is locked, a no-victim flag is raised. The valid and lock bits are kept outside this block, together with the tag storage. A clear-all pulse resets the recency tree, and the owner of the valid bits clears them at the same time. Each translation buffer, such as one for instruction fetches and one for operands, uses its own instance.

Top module: `tlb_plru_victim`

## Requirements
- R1: Synchronous active-high reset drives `victim_o` to 0 and `no_victim_o` to 0, and sets every tree bit to 0. With all entries valid and none locked, the first tree choice after reset is therefore entry ENTRIES-1.
- R2: Both outputs are registered. `victim_o` and `no_victim_o` show, one cycle later, the choice made from the inputs and tree state present before the clock edge. When no force is active and some entry has valid=0 and lock=0, the choice is the lowest-numbered such entry.
- R3: When no force is active and every unlocked entry is valid, the choice is the tree leaf, as long as that leaf is unlocked. The walk starts at the root, which compares the upper half of the index range with the lower half. At each node, a bit value of 1 (upper half more recent) sends the walk to the lower half, and a value of 0 sends it to the upper half. Index bit IDX_W-1 selects the half at the root, and lower index bits select the halves at deeper levels.
- R4: A hit (`hit_i`=1) to an unlocked entry sets every node bit on that entry's path to the value of the matching index bit, so that the entry becomes the most recently used.
- R5: A hit to a locked entry leaves the tree unchanged.
- R6: An allocation (`alloc_i`=1) that has a victim updates the path of the chosen entry in the same way as a hit. If a hit and an allocation arrive in the same cycle, only the allocation updates the tree.
- R7: A locked entry is never chosen unless it is forced. If the tree leaf is locked, the choice is the lowest-numbered unlocked entry.
- R8: If every entry is locked and no force is active, `no_victim_o` is 1 and `victim_o` is 0. An allocation in that cycle does not change the tree.
- R9: When `force_en_i`=1, the choice is `force_idx_i` and `no_victim_o` is 0. An allocation in that cycle updates the tree toward `force_idx_i`.
- R10: When `clear_i`=1, every tree bit is 0 after the edge. Clear takes priority over any hit or allocation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | ENTRIES | Per-entry valid bits |
| lock_i | input | ENTRIES | Per-entry lock bits |
| hit_i | input | 1 | Lookup hit strobe |
| hit_idx_i | input | IDX_W | Index of the entry that hit |
| alloc_i | input | 1 | Allocate strobe; consumes the current choice |
| force_en_i | input | 1 | Use the software-chosen index |
| force_idx_i | input | IDX_W | Software-chosen index |
| clear_i | input | 1 | Clear-all pulse for the recency tree |
| victim_o | output | IDX_W | Registered victim index |
| no_victim_o | output | 1 | Registered flag: every entry is locked |

## Verification
The bench builds the block with its default of 32 entries, so the tree has five levels and 31 node bits. This covers the full root-to-leaf walk and the path update at every depth. Random stimulus keeps most entries valid, which keeps the tree choice active most of the time. It sets sparse lock bits, and often enough a lock lands on the tree leaf to exercise the lowest-unlocked fallback. Directed cases cover the all-locked, forced and clear-with-allocate corners.

// File: rtl/tlb_plru_pkg.sv
package tlb_plru_pkg;
  // Which rule produced the current victim choice.
  typedef enum logic [1:0] {
    SRC_FORCE,
    SRC_FREE,
    SRC_TREE,
    SRC_FALLBACK
  } pick_src_e;
endpackage

// File: rtl/tlb_lowest_set.sv
module tlb_lowest_set #(
  parameter int N = 32,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = i[W-1:0];
    end
  end
endmodule

// File: rtl/tlb_plru_tree.sv
module tlb_plru_tree #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic [IDX_W-1:0] leaf_o
);
  // Node n (heap numbering, root = 1) is stored at slot n-1.
  logic [ENTRIES-2:0] state_q, state_d;

  // Walk toward the less recently used half at every level.
  always_comb begin
    logic [IDX_W-1:0] node;
    logic             dir;
    node   = IDX_W'(1);
    leaf_o = '0;
    for (int lv = 0; lv < IDX_W; lv++) begin
      dir    = ~state_q[node - 1'b1];
      leaf_o = {leaf_o[IDX_W-2:0], dir};
      node   = {node[IDX_W-2:0], dir};
    end
  end

  // Point every node on the path toward the touched entry.
  always_comb begin
    logic [IDX_W-1:0] node;
    logic [IDX_W-1:0] rem;
    state_d = state_q;
    node    = IDX_W'(1);
    rem     = upd_idx_i;
    for (int lv = 0; lv < IDX_W; lv++) begin
      state_d[node - 1'b1] = rem[IDX_W-1];
      node = {node[IDX_W-2:0], rem[IDX_W-1]};
      rem  = rem << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) state_q <= '0;
    else if (upd_i)     state_q <= state_d;
  end

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (state_q == '0));

  assert_upd_mru_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !clear_i) |=> (leaf_o != $past(upd_idx_i)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!upd_i && !clear_i) |=> $stable(state_q));
endmodule

// File: rtl/tlb_plru_victim.sv
module tlb_plru_victim
  import tlb_plru_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] lock_i,
  input  logic               hit_i,
  input  logic [IDX_W-1:0]   hit_idx_i,
  input  logic               alloc_i,
  input  logic               force_en_i,
  input  logic [IDX_W-1:0]   force_idx_i,
  input  logic               clear_i,
  output logic [IDX_W-1:0]   victim_o,
  output logic               no_victim_o
);
  logic             free_found, unl_found, none;
  logic [IDX_W-1:0] free_idx, unl_idx, tree_leaf, pick;
  logic             upd;
  logic [IDX_W-1:0] upd_idx;
  pick_src_e        src;

  tlb_lowest_set #(.N(ENTRIES)) u_free (
    .vec_i(~valid_i & ~lock_i), .found_o(free_found), .idx_o(free_idx));

  tlb_lowest_set #(.N(ENTRIES)) u_unlocked (
    .vec_i(~lock_i), .found_o(unl_found), .idx_o(unl_idx));

  tlb_plru_tree #(.ENTRIES(ENTRIES)) u_tree (
    .clk(clk), .rst(rst), .clear_i(clear_i),
    .upd_i(upd), .upd_idx_i(upd_idx), .leaf_o(tree_leaf));

  always_comb begin
    none = 1'b0;
    if (force_en_i)              begin src = SRC_FORCE;    pick = force_idx_i; end
    else if (free_found)         begin src = SRC_FREE;     pick = free_idx;    end
    else if (!lock_i[tree_leaf]) begin src = SRC_TREE;     pick = tree_leaf;   end
    else begin
      src  = SRC_FALLBACK;
      pick = unl_idx;
      none = !unl_found;
      if (none) pick = '0;
    end
  end

  // Allocation outranks a hit; a locked hit or a failed allocation leaves history alone.
  always_comb begin
    if (alloc_i && !none) begin
      upd     = !clear_i;
      upd_idx = pick;
    end else begin
      upd     = !clear_i && hit_i && !lock_i[hit_idx_i];
      upd_idx = hit_idx_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_o    <= '0;
      no_victim_o <= 1'b0;
    end else begin
      victim_o    <= pick;
      no_victim_o <= none;
    end
  end

  logic [ENTRIES-1:0] victim_hot;
  assign victim_hot = ENTRIES'(1) << victim_o;

  assert_free_first_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(force_en_i) && ($past(~valid_i & ~lock_i) != '0))
      |-> ((victim_hot & $past(valid_i)) == '0));

  assert_never_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(force_en_i) && !no_victim_o)
      |-> ((victim_hot & $past(lock_i)) == '0));

  assert_none_all_locked_R8: assert property (@(posedge clk) disable iff (rst)
    no_victim_o |-> ((&$past(lock_i)) && !$past(force_en_i)));

  assert_force_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(force_en_i))
      |-> (victim_o == $past(force_idx_i) && !no_victim_o));
endmodule

// File: tb/tlb_plru_victim_tb.sv
module tlb_plru_victim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] valid_i, lock_i;
  logic         hit_i, alloc_i, force_en_i, clear_i;
  logic [W-1:0] hit_idx_i, force_idx_i;
  logic [W-1:0] victim_o;
  logic         no_victim_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit [N-2:0] m_tree;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_plru_victim #(.ENTRIES(N)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .lock_i(lock_i),
    .hit_i(hit_i), .hit_idx_i(hit_idx_i), .alloc_i(alloc_i),
    .force_en_i(force_en_i), .force_idx_i(force_idx_i), .clear_i(clear_i),
    .victim_o(victim_o), .no_victim_o(no_victim_o));

  function automatic int tree_walk(bit [N-2:0] t);
    int n = 1;
    for (int l = 0; l < W; l++) n = 2 * n + (t[n-1] ? 0 : 1);
    return n - N;
  endfunction

  function automatic bit [N-2:0] tree_touch(bit [N-2:0] t, int e);
    int n = 1;
    for (int l = 0; l < W; l++) begin
      int b = (e >> (W - 1 - l)) & 1;
      t[n-1] = b[0];
      n = 2 * n + b;
    end
    return t;
  endfunction

  // Returns the chosen index; none_o set when all entries are locked; tag names the rule.
  function automatic int model_pick(output bit none_o, output string tag);
    int leaf;
    none_o = 1'b0;
    if (force_en_i) begin tag = "R9"; return int'(force_idx_i); end
    for (int i = 0; i < N; i++)
      if (!valid_i[i] && !lock_i[i]) begin tag = "R2"; return i; end
    leaf = tree_walk(m_tree);
    if (!lock_i[leaf]) begin tag = "R3"; return leaf; end
    for (int i = 0; i < N; i++)
      if (!lock_i[i]) begin tag = "R7"; return i; end
    none_o = 1'b1;
    tag = "R8";
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: compute expected from pre-edge state, advance model, compare after the edge.
  task automatic cycle(string req);
    bit    none;
    string tag;
    int    exp;
    exp = model_pick(none, tag);
    if (req != "") tag = req;
    if (clear_i)                       m_tree = '0;
    else if (alloc_i && !none)         m_tree = tree_touch(m_tree, exp);
    else if (hit_i && !lock_i[hit_idx_i]) m_tree = tree_touch(m_tree, int'(hit_idx_i));
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(victim_o), exp);
    check(tag, int'(no_victim_o), int'(none));
  endtask

  task automatic idle_inputs();
    hit_i = 0; alloc_i = 0; force_en_i = 0; clear_i = 0;
    hit_idx_i = '0; force_idx_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1; valid_i = '0; lock_i = '0; idle_inputs();
    repeat (3) @(negedge clk);
    check("R1", int'(victim_o), 0);
    check("R1", int'(no_victim_o), 0);
    rst = 0; m_tree = '0;

    // R2: empty entries, lowest first
    valid_i = '0;           cycle("R2");
    valid_i = 32'h0000_001F; cycle("R2");
    // R1: fresh tree with all valid picks the top entry
    valid_i = '1;           cycle("R1");
    // R4: hit entry 31, then tree points elsewhere
    hit_i = 1; hit_idx_i = 5'd31; cycle("R4");
    hit_i = 0;              cycle("R4");
    // R5/R7: locked hit on current leaf leaves tree, fallback picks lowest unlocked
    lock_i = 32'h0000_8000; hit_i = 1; hit_idx_i = 5'd15; cycle("R7");
    lock_i = '0; hit_i = 0; cycle("R5");
    // R6: alloc plus concurrent hit, allocation wins
    alloc_i = 1; hit_i = 1; hit_idx_i = 5'd2; cycle("R6");
    alloc_i = 0; hit_i = 0; cycle("R6");
    // R8: all locked, allocation refused, tree kept
    lock_i = '1; alloc_i = 1; cycle("R8");
    alloc_i = 0; lock_i = '0; cycle("R8");
    // R9: force beats all-locked
    lock_i = '1; force_en_i = 1; force_idx_i = 5'd7; alloc_i = 1; cycle("R9");
    force_en_i = 0; alloc_i = 0; lock_i = '0; cycle("R9");
    // R10: clear beats alloc
    clear_i = 1; alloc_i = 1; cycle("R10");
    clear_i = 0; alloc_i = 0; cycle("R10");

    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      valid_i = (r < 75) ? '1 : ~(N'(1) << $urandom_range(0, N-1)) & ($urandom | $urandom);
      r = $urandom_range(0, 99);
      if (r < 60)      lock_i = '0;
      else if (r < 97) lock_i = (N'(1) << $urandom_range(0, N-1)) | (N'(1) << $urandom_range(0, N-1));
      else             lock_i = '1;
      hit_i       = ($urandom_range(0, 1) == 1);
      hit_idx_i   = W'($urandom_range(0, N-1));
      alloc_i     = ($urandom_range(0, 3) == 0);
      force_en_i  = ($urandom_range(0, 19) == 0);
      force_idx_i = W'($urandom_range(0, N-1));
      clear_i     = ($urandom_range(0, 49) == 0);
      cycle("");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule